// File: doc/BRIEF.md
# I2C EEPROM Target with Chip-Enable Match

This block is a synthesizable, target-side behavioural model of a 2-Mbit serial EEPROM. It does not handle the SCL/SDA wires. Instead it sees the bus as a stream of byte-level events: a START pulse, a STOP pulse, a received byte, and a request for the next byte during a read. For every received byte it returns an acknowledge decision. For every read request it returns a data byte.

The first byte after a START selects the device. Its top nibble must be the EEPROM type code. The next bit must equal the static `chip_en` input. The two bits after that become the top of an 18-bit address pointer, and the last bit gives the direction. Two more bytes, high byte first, complete the pointer. Data bytes that follow are collected in a 256-byte page buffer. The offset wraps inside the page. A STOP moves the collected bytes into the storage RAM during a self-timed write cycle. While that cycle runs, the device refuses its own address, so a host can poll until it is acknowledged again.

Two instances whose `chip_en` inputs are tied to opposite levels answer disjoint halves of a 19-bit linear space: 0h to 3FFFFh and 40000h to 7FFFFh.

Top module: `eeprom_target`

## Requirements
- R1: A device byte whose bits [7:4] are not 4'b1010 is not acknowledged.
- R2: A device byte is acknowledged only if its bit 3 equals `chip_en`.
- R3: After a write-direction device byte (bit 0 = 0), bits [2:1] load pointer bits [17:16]. The next two bytes load pointer bits [15:8] and then [7:0]. Each of these bytes is acknowledged.
- R4: Each write data byte is acknowledged and stored at the pointer's low 8 bits. The offset then increments and wraps from FFh to 00h within the same 256-byte page.
- R5: A STOP that follows at least one write data byte raises `busy` at the next clock edge. `busy` stays high for exactly TWR_CYC cycles, and the page is in storage when it falls.
- R6: While `busy` is high, every device byte is refused. The first device byte sampled after `busy` falls is acknowledged.
- R7: After a read-direction device byte (bit 0 = 1), each `rd_req` produces `rd_valid` with the byte at the pointer one cycle later. The pointer then increments across page boundaries.
- R8: Write data that is not followed directly by a STOP, because a repeated START comes first, is never committed and does not start a write cycle.
- R9: After reset, `busy`, `ack_valid` and `rd_valid` are low.
- R10: Bytes that arrive after a refused device byte, and before the next START, are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Static hardware address level, compared with device byte bit 3 |
| ev_start | input | 1 | START or repeated START seen on the bus (one-cycle pulse) |
| ev_stop | input | 1 | STOP seen on the bus (one-cycle pulse) |
| rx_valid | input | 1 | A byte from the host is present on rx_data |
| rx_data | input | 8 | Received byte |
| rd_req | input | 1 | Host asks for the next read byte |
| ack_valid | output | 1 | Acknowledge decision for the byte of the previous cycle |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_valid | output | 1 | rd_data holds a read byte |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
The end of the write cycle and an acknowledge poll can land on the same clock edge. The case that matters is a device byte sampled in the last busy cycle compared with one sampled in the first free cycle. The bench counts idle cycles after the committing STOP so that a poll byte reaches the design exactly on the final busy edge, where it must be refused. In a second run, the poll byte arrives one edge later, where it must be acknowledged. Immediately after each acknowledged poll, a random read checks that the whole page, including the bytes written after the offset wrapped, had already reached storage.

// File: rtl/eeprom_target_pkg.sv
package eeprom_target_pkg;
    localparam int ADDR_W = 18;
    localparam int PAGE_W = 8;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_AHI,
        ST_ALO,
        ST_WDATA,
        ST_RDATA,
        ST_IGNORE
    } tgt_state_e;
endpackage

// File: rtl/eeprom_devsel_dec.sv
module eeprom_devsel_dec
    import eeprom_target_pkg::*;
(
    input  logic [7:0] dev_byte,
    input  logic       chip_en,
    input  logic       busy,
    output logic       hit,
    output logic       rd_dir,
    output logic [1:0] blk
);
    always_comb begin
        hit    = (dev_byte[7:4] == DEV_TYPE) && (dev_byte[3] == chip_en) && !busy;
        rd_dir = dev_byte[0];
        blk    = dev_byte[2:1];
    end
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [PW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [PW-1:0] ridx,
    output logic [7:0]    rdata,
    output logic          rvalid
);
    localparam int N = 1 << PW;

    logic [7:0]   buf_q [N];
    logic [N-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mask_q <= '0;
        else if (clr) mask_q <= '0;
        else if (we)  mask_q[widx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (we) buf_q[widx] <= wdata;
    end

    always_comb begin
        rdata  = buf_q[ridx];
        rvalid = mask_q[ridx];
    end
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/eeprom_target.sv
module eeprom_target
    import eeprom_target_pkg::*;
#(
    parameter int MEM_AW  = 10,
    parameter int TWR_CYC = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_en,
    input  logic       ev_start,
    input  logic       ev_stop,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rd_req,
    output logic       ack_valid,
    output logic       ack,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       busy
);
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int PG_W   = ADDR_W - PAGE_W;
    localparam int CNT_W  = $clog2(TWR_CYC + 1);

    typedef struct packed {
        tgt_state_e        st;
        logic [ADDR_W-1:0] ptr;
        logic [PG_W-1:0]   page;
        logic              have;
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic              ack_v;
        logic              ack;
        logic              rd_v;
        logic [7:0]        rd_data;
    } regs_t;

    regs_t q, d;

    logic       dev_hit, dev_rd;
    logic [1:0] dev_blk;
    logic       pb_clr, pb_we, pb_valid;
    logic [7:0] pb_rdata, mem_rdata;
    logic       commit_we;
    logic [ADDR_W-1:0] commit_addr;
    tgt_state_e cur_st;

    eeprom_devsel_dec u_dec (
        .dev_byte (rx_data),
        .chip_en  (chip_en),
        .busy     (q.busy),
        .hit      (dev_hit),
        .rd_dir   (dev_rd),
        .blk      (dev_blk)
    );

    assign pb_clr = rx_valid && !ev_start && !ev_stop && (q.st == ST_DEVSEL) && dev_hit && !dev_rd;
    assign pb_we  = rx_valid && !ev_start && !ev_stop && (q.st == ST_WDATA);

    eeprom_page_buf #(.PW(PAGE_W)) u_pbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pb_clr),
        .we     (pb_we),
        .widx   (q.ptr[PAGE_W-1:0]),
        .wdata  (rx_data),
        .ridx   (q.cnt[PAGE_W-1:0]),
        .rdata  (pb_rdata),
        .rvalid (pb_valid)
    );

    assign commit_addr = {q.page, q.cnt[PAGE_W-1:0]};
    assign commit_we   = q.busy && (int'(q.cnt) < PAGE_N) && pb_valid;

    eeprom_store #(.AW(MEM_AW)) u_store (
        .clk   (clk),
        .we    (commit_we),
        .waddr (commit_addr[MEM_AW-1:0]),
        .wdata (pb_rdata),
        .raddr (q.ptr[MEM_AW-1:0]),
        .rdata (mem_rdata)
    );

    always_comb begin
        d         = q;
        d.ack_v   = 1'b0;
        d.ack     = 1'b0;
        d.rd_v    = 1'b0;

        if (q.busy) begin
            if (int'(q.cnt) == TWR_CYC - 1) begin
                d.busy = 1'b0;
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        if (ev_start) begin
            d.st = ST_DEVSEL;
        end else if (ev_stop) begin
            if (q.st == ST_WDATA && q.have) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.page = q.ptr[ADDR_W-1:PAGE_W];
            end
            d.st = ST_IDLE;
        end else if (rx_valid) begin
            d.ack_v = 1'b1;
            case (q.st)
                ST_DEVSEL: begin
                    if (dev_hit) begin
                        d.ack = 1'b1;
                        if (dev_rd) begin
                            d.st = ST_RDATA;
                        end else begin
                            d.ptr[ADDR_W-1:16] = dev_blk;
                            d.have             = 1'b0;
                            d.st               = ST_AHI;
                        end
                    end else begin
                        d.st = ST_IGNORE;
                    end
                end
                ST_AHI: begin
                    d.ack       = 1'b1;
                    d.ptr[15:8] = rx_data;
                    d.st        = ST_ALO;
                end
                ST_ALO: begin
                    d.ack      = 1'b1;
                    d.ptr[7:0] = rx_data;
                    d.st       = ST_WDATA;
                end
                ST_WDATA: begin
                    d.ack                = 1'b1;
                    d.have               = 1'b1;
                    d.ptr[PAGE_W-1:0]    = q.ptr[PAGE_W-1:0] + 1'b1;
                end
                default: d.ack = 1'b0;
            endcase
        end else if (rd_req && q.st == ST_RDATA) begin
            d.rd_v    = 1'b1;
            d.rd_data = mem_rdata;
            d.ptr     = q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur_st    = q.st;
    assign ack_valid = q.ack_v;
    assign ack       = q.ack;
    assign rd_valid  = q.rd_v;
    assign rd_data   = q.rd_data;
    assign busy      = q.busy;
endmodule

// File: rtl/eeprom_target_chk.sv
module eeprom_target_chk
    import eeprom_target_pkg::*;
#(
    parameter int TWR_CYC = 300
) (
    input logic       clk,
    input logic       rst_n,
    input logic       chip_en,
    input logic       ev_start,
    input logic       ev_stop,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rd_req,
    input logic       ack_valid,
    input logic       ack,
    input logic       rd_valid,
    input logic       busy,
    input tgt_state_e cur_st
);
    localparam int BW = $clog2(TWR_CYC + 2);
    logic [BW-1:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    logic dev_byte_now;
    assign dev_byte_now = rx_valid && !ev_start && !ev_stop && (cur_st == ST_DEVSEL);

    assert_bad_type_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_byte_now && rx_data[7:4] != 4'b1010) |=> (ack_valid && !ack));

    assert_ce_mismatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_byte_now && rx_data[3] != chip_en) |=> (ack_valid && !ack));

    assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ev_stop));

    assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (int'(busy_len) == TWR_CYC));

    assert_poll_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_byte_now && busy) |=> (ack_valid && !ack));

    assert_rd_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    assert_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !busy && cur_st != ST_WDATA) |=> !busy);

    assert_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ev_start && !ev_stop && cur_st == ST_IGNORE) |=> (ack_valid && !ack));
endmodule

bind eeprom_target eeprom_target_chk #(.TWR_CYC(TWR_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en   (chip_en),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rd_req    (rd_req),
    .ack_valid (ack_valid),
    .ack       (ack),
    .rd_valid  (rd_valid),
    .busy      (busy),
    .cur_st    (cur_st)
);

// File: tb/eeprom_target_test.sv
module eeprom_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int TWR = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_en = 1'b0;
    logic       ev_start = 1'b0, ev_stop = 1'b0, rx_valid = 1'b0, rd_req = 1'b0;
    logic [7:0] rx_data = '0;
    logic       ack_valid, ack, rd_valid, busy;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit    ack_q[$];
    string ack_tag[$];
    logic [7:0] rd_q[$];
    string rd_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_target #(.MEM_AW(10), .TWR_CYC(TWR)) uut (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en),
        .ev_start(ev_start), .ev_stop(ev_stop),
        .rx_valid(rx_valid), .rx_data(rx_data), .rd_req(rd_req),
        .ack_valid(ack_valid), .ack(ack),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ack_valid) begin
                if (ack_q.size() == 0) check("unexpected ack_valid", 8'd1, 8'd0);
                else check(ack_tag.pop_front(), {7'd0, ack}, {7'd0, ack_q.pop_front()});
            end
            if (rd_valid) begin
                if (rd_q.size() == 0) check("R7 unexpected rd_valid", 8'd1, 8'd0);
                else check(rd_tag.pop_front(), rd_data, rd_q.pop_front());
            end
        end
    end

    task automatic t_start();
        ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
    endtask
    task automatic t_stop();
        ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
    endtask
    task automatic t_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        ack_q.push_back(exp_ack); ack_tag.push_back(tag);
        rx_data = b; rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
    endtask
    task automatic t_read(input logic [7:0] exp, input string tag);
        rd_q.push_back(exp); rd_tag.push_back(tag);
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    endtask
    task automatic t_idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] devb(input logic [17:0] a, input bit rd);
        return {4'b1010, chip_en, a[17:16], rd};
    endfunction

    // address phase shared by writes and random reads
    task automatic t_addr(input logic [17:0] a, input string tag);
        t_start();
        t_byte(devb(a, 1'b0), 1'b1, {tag, " R3 dev"});
        t_byte(a[15:8], 1'b1, {tag, " R3 hi"});
        t_byte(a[7:0],  1'b1, {tag, " R3 lo"});
    endtask

    task automatic t_rd_open(input logic [17:0] a, input string tag);
        t_addr(a, tag);
        t_start();
        t_byte(devb(a, 1'b1), 1'b1, {tag, " R7 dev read"});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_idle(3);
        // R9 reset state
        check("R9 busy in reset", {7'd0, busy}, 8'd0);
        check("R9 ack_valid in reset", {7'd0, ack_valid}, 8'd0);
        check("R9 rd_valid in reset", {7'd0, rd_valid}, 8'd0);
        rst_n = 1'b1;
        t_idle(2);

        // R1 wrong type code, R10 following byte ignored
        t_start();
        t_byte(8'hB0, 1'b0, "R1 type 1011");
        t_byte(8'h55, 1'b0, "R10 byte after refusal");
        t_start();
        t_byte(8'h20, 1'b0, "R1 type 0010");
        t_stop();
        check("R8 no busy without data", {7'd0, busy}, 8'd0);

        // R4 page wrap write: FE,FF then 00 of page 0
        t_addr(18'h000FE, "wrapw");
        t_byte(8'h11, 1'b1, "R4 data ack");
        t_byte(8'h22, 1'b1, "R4 data ack");
        t_byte(8'h33, 1'b1, "R4 data ack wrapped");
        t_stop();
        check("R5 busy after stop", {7'd0, busy}, 8'd1);
        t_idle(TWR - 2);
        check("R5 busy before end", {7'd0, busy}, 8'd1);
        t_start();
        t_byte(devb(18'h0, 1'b0), 1'b0, "R6 poll on last busy cycle");
        check("R5 busy low after TWR", {7'd0, busy}, 8'd0);
        t_stop();

        // second page byte, then poll on first free cycle
        t_addr(18'h00100, "p1w");
        t_byte(8'h44, 1'b1, "R4 data ack");
        t_stop();
        t_idle(TWR - 1);
        t_start();
        t_byte(devb(18'h0, 1'b0), 1'b1, "R6 poll on first free cycle");
        t_byte(8'h00, 1'b1, "R3 hi after poll");
        t_byte(8'hFE, 1'b1, "R3 lo after poll");
        t_start();
        t_byte(devb(18'h0, 1'b1), 1'b1, "R7 dev read");
        t_read(8'h11, "R7 read FE");
        t_read(8'h22, "R7 read FF");
        t_read(8'h44, "R7 read crosses into next page");
        t_stop();
        t_rd_open(18'h00000, "wrapr");
        t_read(8'h33, "R4 wrapped byte at offset 00");
        t_stop();

        // R2 / R3 with chip enable high and upper address bits
        chip_en = 1'b1;
        t_idle(1);
        t_start();
        t_byte(8'hA4, 1'b0, "R2 ce bit 0 while pin high");
        t_stop();
        t_addr(18'h20140, "hiw");
        t_byte(8'h55, 1'b1, "R4 data ack");
        t_byte(8'h66, 1'b1, "R4 data ack");
        t_stop();
        t_idle(TWR + 2);
        t_rd_open(18'h20140, "hir");
        t_read(8'h55, "R3 read upper address");
        t_read(8'h66, "R3 read upper address next");
        t_stop();

        // R8 data followed by repeated START is discarded
        t_addr(18'h20140, "nocommit");
        t_byte(8'h77, 1'b1, "R4 data ack");
        t_start();
        t_stop();
        check("R8 no busy after repeated start", {7'd0, busy}, 8'd0);
        t_rd_open(18'h20140, "nocommitr");
        t_read(8'h55, "R8 old data kept");
        t_stop();

        chip_en = 1'b0;
        t_idle(1);
        t_start();
        t_byte(8'hA8, 1'b0, "R2 ce bit 1 while pin low");
        t_stop();
        t_idle(3);

        check("scoreboard ack queue drained", 8'(ack_q.size()), 8'd0);
        check("R7 scoreboard read queue drained", 8'(rd_q.size()), 8'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule